// File: doc/BRIEF.md
# Branch Queue and Test Unit

This block sits between a branch lookahead stage and the dispatch logic of a superscalar core. The lookahead stage finds branches early and writes them, already decoded and predicted, into a small queue. Each queued entry keeps the decoded branch fields, the computed target, the address of the instruction after the branch and the predicted direction. The lookahead stage is told to stop whenever every slot is occupied.

The branch itself never travels with the dispatched group. When dispatch meets a branch in program order it pulses a strobe, and the oldest queued entry then moves into a two-stage pipe. In the first stage the entry is latched and its queue slot is released. In the second stage the real condition result and the real target, supplied by the condition logic, are compared with what was stored. A wrong direction, or a taken branch whose real target differs from the stored one, raises a cancel. That cancel kills every younger instruction, including the two that may have been dispatched in the same group as the branch. It also supplies the address fetch must restart from. The queue and the decode stage hold wrong-path work at that point, so both are emptied.

A strobe that arrives while the queue is empty is remembered, and it is served as soon as an entry is written.

Top module: `brq_test_unit`

## Requirements
- R1: The queue holds at most DEPTH (default 3) entries. `la_stall` is high exactly when all DEPTH entries are occupied. A write offered while `la_stall` is high is dropped and never reaches execute.
- R2: Entries leave in the order they were written. The `ex_dec` and `ex_pred` values seen in execute equal the `la_dec` and `la_pred` values written for that entry.
- R3: When `disp_br` is high in cycle N and the queue is not empty, the head entry is removed. It occupies decode in cycle N+1 and is shown in execute (`ex_valid` high) in cycle N+2. A removal from a full queue in cycle N makes `la_stall` low in cycle N+1.
- R4: In an execute cycle `cancel` is high, in that same cycle, exactly when `act_taken` differs from the stored prediction, or when both are taken and `act_tgt` differs from the stored target. `cancel` is never high without `ex_valid`.
- R5: While `cancel` is high, `refetch_addr` equals `act_tgt` if `act_taken` is 1, and the stored next sequential address if `act_taken` is 0.
- R6: A correctly predicted branch raises no cancel. A branch that is predicted not taken and is really not taken raises no cancel whatever `act_tgt` holds.
- R7: A cancel in cycle N empties the queue, drops the branch in decode, drops any held strobes and drops a lookahead write offered in cycle N. In cycle N+1 `la_stall` and `ex_valid` are both low.
- R8: Strobes that arrive while the queue is empty are held, up to DEPTH of them. Each held strobe then removes one entry per cycle, starting in the cycle after an entry is written. No entry is removed without a strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| la_valid | input | 1 | Lookahead offers an entry this cycle |
| la_dec | input | 12 | Decoded branch fields of the offered entry |
| la_tgt | input | 32 | Computed branch target |
| la_seq | input | 32 | Next sequential address after the branch |
| la_pred | input | 1 | Predicted taken flag |
| la_stall | output | 1 | Queue full; the lookahead must hold |
| disp_br | input | 1 | Dispatch reached a branch (consume one entry) |
| act_taken | input | 1 | Real condition outcome of the branch in execute |
| act_tgt | input | 32 | Real target of the branch in execute |
| ex_valid | output | 1 | A branch is in the execute stage |
| ex_dec | output | 12 | Decoded fields of the branch in execute |
| ex_pred | output | 1 | Stored prediction of the branch in execute |
| cancel | output | 1 | Misprediction: cancel younger work and refetch |
| refetch_addr | output | 32 | Address to restart fetch from while cancel is high |

## Verification
Random traffic varies the rate of lookahead writes against the rate of dispatch strobes. Slow dispatch keeps the queue full and exercises the stall and the dropping of writes. Fast dispatch drains the queue and exercises the holding of strobes. The execute-stage outcome is driven in three patterns: matching the prediction, inverting the direction, and taken with a wrong target. These separate direction errors from target errors, and they show that the refetch address picks the target or the sequential address as required. Directed sequences fill the queue past capacity, issue strobes into an empty queue and flush a full queue. The bench predicts each of these results cycle by cycle.

// File: rtl/brq_pkg.sv
package brq_pkg;

    localparam int BQ_ADDR_W = 32;
    localparam int BQ_DEC_W  = 12;

    typedef struct packed {
        logic [BQ_DEC_W-1:0]  dec;
        logic [BQ_ADDR_W-1:0] tgt;
        logic [BQ_ADDR_W-1:0] seq;
        logic                 pred;
    } brq_entry_t;

    // A branch is wrong when its direction differs, or when it is really
    // taken to a different place than the one stored.
    function automatic logic brq_wrong(input brq_entry_t e,
                                       input logic taken,
                                       input logic [BQ_ADDR_W-1:0] real_tgt);
        return (taken != e.pred) || (taken && (real_tgt != e.tgt));
    endfunction

    function automatic logic [BQ_ADDR_W-1:0] brq_restart(input brq_entry_t e,
                                                         input logic taken,
                                                         input logic [BQ_ADDR_W-1:0] real_tgt);
        return taken ? real_tgt : e.seq;
    endfunction

endpackage

// File: rtl/brq_fifo.sv
module brq_fifo
    import brq_pkg::*;
#(
    parameter int DEPTH = 3
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       clr,
    input  logic       wr_en,
    input  brq_entry_t wr_data,
    input  logic       rd_en,
    output brq_entry_t rd_data,
    output logic       full,
    output logic       empty
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULLC = CNT_W'(DEPTH);

    brq_entry_t       slots [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] count;
    logic             do_wr, do_rd;

    assign full    = (count == FULLC);
    assign empty   = (count == '0);
    assign do_wr   = wr_en && !full && !clr;
    assign do_rd   = rd_en && !empty && !clr;
    assign rd_data = slots[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_wr) slots[wr_ptr] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_wr) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            if (do_rd) rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            case ({do_wr, do_rd})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        (full && wr_en && !rd_en && !clr) |=> full); // R1
    AST_NO_UNDERRUN: assert property (@(posedge clk) disable iff (rst)
        rd_en |-> !empty); // R8

endmodule

// File: rtl/brq_pipe.sv
module brq_pipe
    import brq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       flush,
    input  logic       load,
    input  brq_entry_t load_entry,
    output logic       ex_valid,
    output brq_entry_t ex_entry
);
    logic       dec_valid;
    brq_entry_t dec_entry;

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            dec_valid <= 1'b0;
            ex_valid  <= 1'b0;
        end else begin
            dec_valid <= load;
            ex_valid  <= dec_valid;
        end
    end

    always_ff @(posedge clk) begin
        if (load) dec_entry <= load_entry;
        ex_entry <= dec_entry;
    end

    AST_DEC_TO_EX: assert property (@(posedge clk) disable iff (rst)
        (load && !flush) |=> ##1 ($past(flush) || ex_valid)); // R3

endmodule

// File: rtl/brq_exec.sv
module brq_exec
    import brq_pkg::*;
(
    input  logic                 ex_valid,
    input  brq_entry_t           ex_entry,
    input  logic                 act_taken,
    input  logic [BQ_ADDR_W-1:0] act_tgt,
    output logic                 cancel,
    output logic [BQ_ADDR_W-1:0] refetch_addr
);
    always_comb begin
        cancel       = ex_valid && brq_wrong(ex_entry, act_taken, act_tgt);
        refetch_addr = brq_restart(ex_entry, act_taken, act_tgt);
    end
endmodule

// File: rtl/brq_test_unit.sv
module brq_test_unit
    import brq_pkg::*;
#(
    parameter int DEPTH = 3
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 la_valid,
    input  logic [BQ_DEC_W-1:0]  la_dec,
    input  logic [BQ_ADDR_W-1:0] la_tgt,
    input  logic [BQ_ADDR_W-1:0] la_seq,
    input  logic                 la_pred,
    output logic                 la_stall,
    input  logic                 disp_br,
    input  logic                 act_taken,
    input  logic [BQ_ADDR_W-1:0] act_tgt,
    output logic                 ex_valid,
    output logic [BQ_DEC_W-1:0]  ex_dec,
    output logic                 ex_pred,
    output logic                 cancel,
    output logic [BQ_ADDR_W-1:0] refetch_addr
);
    localparam int PEND_W = $clog2(DEPTH + 1);
    localparam logic [PEND_W:0] PEND_MAX = (PEND_W+1)'(DEPTH);

    brq_entry_t        wr_entry, head, ex_entry;
    logic              q_full, q_empty, pop;
    logic [PEND_W-1:0] pend_cnt;
    logic [PEND_W:0]   pend_sum;

    assign wr_entry = '{dec: la_dec, tgt: la_tgt, seq: la_seq, pred: la_pred};
    assign la_stall = q_full;
    assign pop      = !cancel && !q_empty && (disp_br || (pend_cnt != '0));

    // Strobes seen with nothing to consume are counted and served later.
    always_comb begin
        pend_sum = {1'b0, pend_cnt} + {{PEND_W{1'b0}}, disp_br} - {{PEND_W{1'b0}}, pop};
        if (pend_sum > PEND_MAX) pend_sum = PEND_MAX;
    end

    always_ff @(posedge clk) begin
        if (rst || cancel) pend_cnt <= '0;
        else               pend_cnt <= pend_sum[PEND_W-1:0];
    end

    brq_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk     (clk),
        .rst     (rst),
        .clr     (cancel),
        .wr_en   (la_valid),
        .wr_data (wr_entry),
        .rd_en   (pop),
        .rd_data (head),
        .full    (q_full),
        .empty   (q_empty)
    );

    brq_pipe u_pipe (
        .clk        (clk),
        .rst        (rst),
        .flush      (cancel),
        .load       (pop),
        .load_entry (head),
        .ex_valid   (ex_valid),
        .ex_entry   (ex_entry)
    );

    brq_exec u_exec (
        .ex_valid     (ex_valid),
        .ex_entry     (ex_entry),
        .act_taken    (act_taken),
        .act_tgt      (act_tgt),
        .cancel       (cancel),
        .refetch_addr (refetch_addr)
    );

    assign ex_dec  = ex_entry.dec;
    assign ex_pred = ex_entry.pred;

    AST_CANCEL_IN_EX: assert property (@(posedge clk) disable iff (rst)
        cancel |-> ex_valid); // R4
    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (rst)
        cancel |=> (q_empty && !ex_valid && !la_stall)); // R7
    AST_HOLD_STROBE: assert property (@(posedge clk) disable iff (rst)
        (disp_br && q_empty && !cancel) |=> (pend_cnt != '0)); // R8
    AST_SLOT_FREED: assert property (@(posedge clk) disable iff (rst)
        (q_full && pop) |=> !la_stall); // R3

endmodule

// File: tb/brq_test_unit_tb.sv
module brq_test_unit_tb;
    import brq_pkg::*;

    localparam int DEPTH = 3;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic                 la_valid = 1'b0;
    logic [BQ_DEC_W-1:0]  la_dec = '0;
    logic [BQ_ADDR_W-1:0] la_tgt = '0;
    logic [BQ_ADDR_W-1:0] la_seq = '0;
    logic                 la_pred = 1'b0;
    logic                 la_stall;
    logic                 disp_br = 1'b0;
    logic                 act_taken = 1'b0;
    logic [BQ_ADDR_W-1:0] act_tgt = '0;
    logic                 ex_valid;
    logic [BQ_DEC_W-1:0]  ex_dec;
    logic                 ex_pred;
    logic                 cancel;
    logic [BQ_ADDR_W-1:0] refetch_addr;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    brq_test_unit #(.DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst(rst),
        .la_valid(la_valid), .la_dec(la_dec), .la_tgt(la_tgt), .la_seq(la_seq),
        .la_pred(la_pred), .la_stall(la_stall), .disp_br(disp_br),
        .act_taken(act_taken), .act_tgt(act_tgt),
        .ex_valid(ex_valid), .ex_dec(ex_dec), .ex_pred(ex_pred),
        .cancel(cancel), .refetch_addr(refetch_addr)
    );

    // Reference state built from the requirements.
    brq_entry_t mq[$];
    int         mpend = 0;
    bit         md_v = 0, mx_v = 0;
    brq_entry_t md_e, mx_e;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic bit exp_wrong(input brq_entry_t e, input logic t, input logic [BQ_ADDR_W-1:0] a);
        if (t != e.pred) return 1'b1;
        if (t && (a != e.tgt)) return 1'b1;
        return 1'b0;
    endfunction

    function automatic brq_entry_t rand_entry();
        brq_entry_t e;
        e.dec  = BQ_DEC_W'($urandom);
        e.tgt  = $urandom;
        e.seq  = $urandom;
        e.pred = 1'($urandom);
        return e;
    endfunction

    // Set the real outcome for the branch in execute. mode 0: matches the
    // prediction, 1: direction inverted, 2: taken with a wrong target.
    task automatic set_outcome(input int mode);
        if (!mx_v || mode == 0) begin
            act_taken = mx_v ? mx_e.pred : 1'($urandom);
            act_tgt   = (mx_v && mx_e.pred) ? mx_e.tgt : $urandom;
        end else if (mode == 1) begin
            act_taken = !mx_e.pred;
            act_tgt   = mx_e.tgt;
        end else begin
            act_taken = 1'b1;
            act_tgt   = mx_e.tgt ^ 32'h0000_0040;
        end
    endtask

    // One cycle: inputs are already driven after a falling edge.
    task automatic step(input string phase);
        bit wrong, popm;
        int sz;
        #1;
        wrong = mx_v && exp_wrong(mx_e, act_taken, act_tgt);
        chk({"R1 la_stall ", phase}, 64'(la_stall), 64'(mq.size() == DEPTH));
        chk({"R3 ex_valid ", phase}, 64'(ex_valid), 64'(mx_v));
        if (mx_v) begin
            chk({"R2 ex_dec ", phase}, 64'(ex_dec), 64'(mx_e.dec));
            chk({"R2 ex_pred ", phase}, 64'(ex_pred), 64'(mx_e.pred));
        end
        chk({wrong ? "R4 cancel " : "R6 cancel ", phase}, 64'(cancel), 64'(wrong));
        if (wrong)
            chk({"R5 refetch_addr ", phase}, 64'(refetch_addr),
                64'(act_taken ? act_tgt : mx_e.seq));
        if (wrong) begin
            mq.delete();
            mpend = 0;
            md_v  = 0;
            mx_v  = 0;
        end else begin
            sz   = mq.size();
            popm = (disp_br || mpend > 0) && sz > 0;
            mx_v = md_v;
            mx_e = md_e;
            md_v = popm;
            if (popm) md_e = mq.pop_front();
            if (la_valid && sz < DEPTH)
                mq.push_back('{dec: la_dec, tgt: la_tgt, seq: la_seq, pred: la_pred});
            mpend = mpend + int'(disp_br) - int'(popm);
            if (mpend > DEPTH) mpend = DEPTH;
        end
        @(negedge clk);
    endtask

    task automatic drive(input bit lv, input bit db, input int mode);
        brq_entry_t e;
        e = rand_entry();
        la_valid = lv;
        la_dec = e.dec; la_tgt = e.tgt; la_seq = e.seq; la_pred = e.pred;
        disp_br = db;
        set_outcome(mode);
    endtask

    initial begin
        void'($urandom(32'h5EED_0B0E));
        repeat (3) @(posedge clk);
        #1;
        chk("R1 reset la_stall", 64'(la_stall), 64'd0);
        chk("R3 reset ex_valid", 64'(ex_valid), 64'd0);
        chk("R4 reset cancel", 64'(cancel), 64'd0);
        @(negedge clk);
        rst = 1'b0;

        // R1: four writes without strobes, the fourth is dropped.
        for (int i = 0; i < 4; i++) begin drive(1, 0, 0); step("R1 fill"); end
        drive(0, 0, 0); step("R1 full");
        // R2, R6: drain in order with correct predictions.
        for (int i = 0; i < 6; i++) begin drive(0, i < 3, 0); step("R2 drain"); end
        // R8: two strobes into an empty queue, then two writes.
        for (int i = 0; i < 2; i++) begin drive(0, 1, 0); step("R8 held"); end
        drive(1, 0, 0); step("R8 write");
        drive(1, 0, 0); step("R8 write");
        for (int i = 0; i < 5; i++) begin drive(0, 0, 0); step("R8 served"); end
        // R7: fill, send one branch, mispredict it while a write is offered.
        for (int i = 0; i < 3; i++) begin drive(1, 0, 0); step("R7 fill"); end
        drive(1, 1, 0); step("R7 strobe");
        drive(1, 0, 0); step("R7 decode");
        drive(1, 0, 1); step("R7 flush");
        drive(0, 0, 0); step("R7 after");
        // R5: target error on a taken branch.
        drive(1, 0, 0); step("R5 write");
        drive(0, 1, 0); step("R5 strobe");
        drive(0, 0, 0); step("R5 decode");
        drive(0, 0, 2); step("R5 wrong target");
        drive(0, 0, 0); step("R5 after");

        // Random traffic with varied rates and outcome patterns.
        for (int i = 0; i < 4000; i++) begin
            int wr_pct, db_pct, r;
            wr_pct = (i / 500) % 2 ? 80 : 35;
            db_pct = (i / 500) % 2 ? 30 : 70;
            r = $urandom_range(99);
            drive(($urandom_range(99) < wr_pct), ($urandom_range(99) < db_pct),
                  (r < 70) ? 0 : ((r < 85) ? 1 : 2));
            step("random");
        end
        done = 1;
    end

    initial begin
        fork
            begin wait (done); end
            begin
                repeat (150000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule